// File: doc/BRIEF.md
# CAN Frame Timestamp Timer

This block keeps a 16-bit time base for a CAN controller and uses it to stamp frames. The count advances only while the controller reports itself enabled. Each step comes from a programmable clock divider. When the protocol engine signals that a frame has been received or sent by a given mailbox, the count at that moment is copied into that mailbox's stamp slot.

Dropping the enable flag freezes the count and the divider. Raising it again resumes from where they stopped. Only the chip reset or the block's software reset returns the count to zero. A wrap of the count from all-ones to zero raises a sticky overflow flag. Software can extend the time base from that flag, and it acknowledges the flag with a clear pulse.

Top module: `can_stamp_timer`

## Requirements
- R1: After `rst`, `tm_count` is 0x0000, `tm_wrap_flag` is 0 and every stamp slot in `tm_stamps` is 0x0000.
- R2: After a reset, the count starts at 0x0000 and rises by exactly one per divider tick, beginning with the first enabled cycle.
- R3: With divider value N on `tm_div`, the count advances once every N+1 enabled clock cycles; N = 0 advances it on every enabled cycle.
- R4: While `ctl_enabled` is low, the count and the divider phase are held. When it rises again, counting resumes from the held values and is not zeroed.
- R5: A tick taken while the count is 0xFFFF turns the count to 0x0000 and sets `tm_wrap_flag` on the same clock edge.
- R6: `tm_wrap_flag` stays set until a one-cycle `wrap_clr` pulse clears it. If a clear and a wrap fall on the same edge, the flag stays set.
- R7: A cycle with `rx_done` high copies the value `tm_count` shows in that cycle, before any increment on that edge, into slot `rx_mbox`. The stamp appears one cycle later, and the other slots are unchanged. Slot i occupies bits [16i+15:16i] of `tm_stamps`.
- R8: `tx_done` with `tx_mbox` stamps in the same way. When both strobes arrive in one cycle for different slots, both slots take the same value.
- R9: A one-cycle `sw_rst` zeroes the count, the divider phase, the flag and all stamps on the next edge, even while enabled, and counting then restarts from 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| sw_rst | input | 1 | Synchronous software reset of the whole block |
| ctl_enabled | input | 1 | Controller enabled status; counting runs while high |
| tm_div | input | 8 | Divider value N; one count per N+1 enabled cycles |
| rx_done | input | 1 | One-cycle strobe: a frame was received |
| rx_mbox | input | 3 | Mailbox index that received the frame |
| tx_done | input | 1 | One-cycle strobe: a frame was sent |
| tx_mbox | input | 3 | Mailbox index that sent the frame |
| wrap_clr | input | 1 | One-cycle clear of the overflow flag |
| tm_count | output | 16 | Current count |
| tm_wrap_flag | output | 1 | Sticky overflow flag |
| tm_stamps | output | 128 | Stamp slots; slot i at bits [16i+15:16i] |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same edge as a second wrap. Both wraps need a run of 65536 undivided ticks. The stimulus first uses a software reset to zero the count, then keeps divider value 0 enabled through a first wrap without clearing the flag. It then counts 65535 further cycles and drives the clear pulse on the exact edge where the count leaves 0xFFFF. Holding through disable is shown separately, by a table of enable and disable segments under several divider values. In that table the divider phase carries across each gap.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int STAMP_CNT_W  = 16;
  localparam int STAMP_DIV_W  = 8;
  localparam int STAMP_MBOXES = 8;
endpackage

// File: rtl/stamp_prescale.sv
module stamp_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             at_end;

  // >= keeps the phase bounded when div_val is lowered mid-run
  assign at_end = (phase_q >= div_val);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
  end

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst || sw_rst)
    !run |=> $stable(phase_q));
  assert_phase_clear_R9: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (phase_q == '0));
endmodule

// File: rtl/stamp_count.sv
module stamp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic wrap_now;

  assign wrap_now = tick && (count_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      wrap_q <= 1'b0;
    end else if (wrap_now) begin
      wrap_q <= 1'b1;
    end else if (wrap_clr) begin
      wrap_q <= 1'b0;
    end
  end

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst || sw_rst)
    !run |=> $stable(count_q));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst || sw_rst)
    tick |=> (count_q == $past(count_q) + 1'b1));
  assert_wrap_set_R5: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (tick && count_q == TOP) |=> (wrap_q && count_q == '0));
  assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (wrap_q && !wrap_clr) |=> wrap_q);
  assert_count_clear_R9: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (count_q == '0 && !wrap_q));
endmodule

// File: rtl/stamp_store.sv
module stamp_store #(
  parameter int CNT_W  = 16,
  parameter int NUM_MB = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_rst,
  input  logic [CNT_W-1:0]        count,
  input  logic                    rx_hit,
  input  logic [IDX_W-1:0]        rx_idx,
  input  logic                    tx_hit,
  input  logic [IDX_W-1:0]        tx_idx,
  output logic [NUM_MB*CNT_W-1:0] stamps
);
  logic [CNT_W-1:0] slot_q [NUM_MB];

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic take;
    assign take = (rx_hit && rx_idx == IDX_W'(g)) || (tx_hit && tx_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || sw_rst) begin
        slot_q[g] <= '0;
      end else if (take) begin
        slot_q[g] <= count;
      end
    end

    assign stamps[g*CNT_W +: CNT_W] = slot_q[g];
  end

  assert_rx_stamp_R7: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (rx_hit && int'(rx_idx) < NUM_MB) |=> (slot_q[$past(rx_idx)] == $past(count)));
  assert_tx_stamp_R8: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (tx_hit && int'(tx_idx) < NUM_MB) |=> (slot_q[$past(tx_idx)] == $past(count)));
endmodule

// File: rtl/can_stamp_timer.sv
module can_stamp_timer
  import stamp_pkg::*;
#(
  parameter  int CNT_W  = STAMP_CNT_W,
  parameter  int DIV_W  = STAMP_DIV_W,
  parameter  int NUM_MB = STAMP_MBOXES,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_rst,
  input  logic                    ctl_enabled,
  input  logic [DIV_W-1:0]        tm_div,
  input  logic                    rx_done,
  input  logic [IDX_W-1:0]        rx_mbox,
  input  logic                    tx_done,
  input  logic [IDX_W-1:0]        tx_mbox,
  input  logic                    wrap_clr,
  output logic [CNT_W-1:0]        tm_count,
  output logic                    tm_wrap_flag,
  output logic [NUM_MB*CNT_W-1:0] tm_stamps
);
  logic tick;

  stamp_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .run(ctl_enabled),
    .div_val(tm_div), .tick(tick)
  );

  stamp_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .run(ctl_enabled), .tick(tick),
    .wrap_clr(wrap_clr), .count_q(tm_count), .wrap_q(tm_wrap_flag)
  );

  stamp_store #(.CNT_W(CNT_W), .NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .count(tm_count),
    .rx_hit(rx_done), .rx_idx(rx_mbox), .tx_hit(tx_done), .tx_idx(tx_mbox),
    .stamps(tm_stamps)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (tm_count == '0 && !tm_wrap_flag && tm_stamps == '0));
endmodule

// File: tb/can_stamp_timer_bench.sv
module can_stamp_timer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sw_rst = 1'b0;
  logic         ctl_enabled = 1'b0;
  logic [7:0]   tm_div = 8'd0;
  logic         rx_done = 1'b0;
  logic [2:0]   rx_mbox = 3'd0;
  logic         tx_done = 1'b0;
  logic [2:0]   tx_mbox = 3'd0;
  logic         wrap_clr = 1'b0;
  logic [15:0]  tm_count;
  logic         tm_wrap_flag;
  logic [127:0] tm_stamps;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_stamp_timer u_can_stamp_timer (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .ctl_enabled(ctl_enabled),
    .tm_div(tm_div), .rx_done(rx_done), .rx_mbox(rx_mbox), .tx_done(tx_done),
    .tx_mbox(tx_mbox), .wrap_clr(wrap_clr), .tm_count(tm_count),
    .tm_wrap_flag(tm_wrap_flag), .tm_stamps(tm_stamps)
  );

  // segment: divider, enabled cycles, disabled cycles, expected count afterwards
  localparam logic [55:0] SEGS [0:5] = '{
    {8'd0,   16'd10,  16'd5, 16'd10},
    {8'd3,   16'd8,   16'd4, 16'd12},
    {8'd3,   16'd6,   16'd3, 16'd13},
    {8'd3,   16'd2,   16'd2, 16'd14},
    {8'd1,   16'd6,   16'd3, 16'd17},
    {8'd255, 16'd300, 16'd4, 16'd18}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] slot(input int i);
    return tm_stamps[i*16 +: 16];
  endfunction

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1: reset state
    chk("R1 count", 32'(tm_count), 32'h0);
    chk("R1 flag", 32'(tm_wrap_flag), 32'h0);
    chk("R1 stamps", 32'(tm_stamps == '0), 32'h1);

    // R2 R3 R4: segments of enable and disable under several dividers
    for (int s = 0; s < 6; s++) begin
      tm_div = SEGS[s][55:48];
      ctl_enabled = 1'b1;
      cyc(int'(SEGS[s][47:32]));
      ctl_enabled = 1'b0;
      cyc(int'(SEGS[s][31:16]));
      chk($sformatf("R3 R4 seg%0d", s), 32'(tm_count), 32'(SEGS[s][15:0]));
      if (s == 0) chk("R2 start from zero", 32'(tm_count), 32'd10);
    end

    // R7: capture while frozen
    rx_done = 1'b1; rx_mbox = 3'd2;
    cyc(1);
    rx_done = 1'b0;
    chk("R7 slot2", 32'(slot(2)), 32'd18);
    chk("R7 slot3 untouched", 32'(slot(3)), 32'd0);

    // R7 R8: simultaneous rx and tx while counting, stamp is pre-increment
    tm_div = 8'd0; ctl_enabled = 1'b1;
    rx_done = 1'b1; rx_mbox = 3'd5; tx_done = 1'b1; tx_mbox = 3'd6;
    cyc(1);
    rx_done = 1'b0;
    tx_mbox = 3'd5;
    chk("R7 slot5", 32'(slot(5)), 32'd18);
    chk("R8 slot6", 32'(slot(6)), 32'd18);
    chk("R3 count", 32'(tm_count), 32'd19);
    cyc(1);
    tx_done = 1'b0; ctl_enabled = 1'b0;
    chk("R8 slot5 restamp", 32'(slot(5)), 32'd19);
    rx_done = 1'b1; tx_done = 1'b1; rx_mbox = 3'd1; tx_mbox = 3'd1;
    cyc(1);
    rx_done = 1'b0; tx_done = 1'b0;
    chk("R8 same slot", 32'(slot(1)), 32'd20);

    // R9: software reset while enabled
    ctl_enabled = 1'b1; sw_rst = 1'b1;
    cyc(1);
    sw_rst = 1'b0;
    chk("R9 count", 32'(tm_count), 32'd0);
    chk("R9 stamps", 32'(tm_stamps == '0), 32'h1);
    cyc(1);
    chk("R9 restart", 32'(tm_count), 32'd1);

    // R5: first wrap
    cyc(65534);
    chk("R5 at top", 32'(tm_count), 32'hFFFF);
    chk("R5 no flag yet", 32'(tm_wrap_flag), 32'h0);
    cyc(1);
    chk("R5 wrapped", 32'(tm_count), 32'h0);
    chk("R5 flag", 32'(tm_wrap_flag), 32'h1);

    // R6: sticky, then clear colliding with second wrap
    cyc(65535);
    chk("R6 sticky", 32'(tm_wrap_flag), 32'h1);
    chk("R6 at top", 32'(tm_count), 32'hFFFF);
    wrap_clr = 1'b1;
    cyc(1);
    wrap_clr = 1'b0; ctl_enabled = 1'b0;
    chk("R6 wrap beats clear", 32'(tm_wrap_flag), 32'h1);
    wrap_clr = 1'b1;
    cyc(1);
    wrap_clr = 1'b0;
    chk("R6 cleared", 32'(tm_wrap_flag), 32'h0);
    cyc(3);
    chk("R6 stays clear", 32'(tm_wrap_flag), 32'h0);
    chk("R4 held", 32'(tm_count), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule